// File: doc/BRIEF.md
# Nibble Rotate Read-Modify-Write Sequencer

The block carries out the two nibble-rotate operations between an 8-bit accumulator it holds and one byte of external memory. A rotate moves twelve bits as one group: the low four bits of the accumulator and both halves of the memory byte. The accumulator's upper four bits stay where they are. Each operation is a read-modify-write on a simple synchronous memory port. The block reads the byte, waits one cycle for the data, computes the new accumulator and the new byte, and writes the byte back to the same address. It then pulses done for one cycle.

A start pulse launches an operation. A direction bit picks the left or the right rotate, and an address input names the byte. The block also holds a flag byte. A rotate updates sign, zero and parity from the new accumulator, clears three of the flags and leaves carry unchanged. A load port sets the accumulator and the flags between operations.

Top module: `nib_rot_seq`

## Requirements
- R1: After reset the accumulator and flag outputs are 0x00, and the read enable, write enable, busy and done outputs are all low.
- R2: For a left rotate (dir_right_i=0), the new accumulator is {old accumulator[7:4], memory[7:4]}.
- R3: For a left rotate, the byte written back is {memory[3:0], old accumulator[3:0]}.
- R4: For a right rotate (dir_right_i=1), the new accumulator is {old accumulator[7:4], memory[3:0]}, and the byte written back is {old accumulator[3:0], memory[7:4]}.
- R5: Each operation makes exactly one read and then exactly one write, both at the address captured with start. Counting from the cycle in which start is sampled as cycle 0, the read enable is high in cycle 1, the write enable is high in cycle 3 and done is high in cycle 4.
- R6: Flag byte layout: bit7 sign, bit6 zero, bit5 unused, bit4 half-carry, bit3 extra, bit2 parity, bit1 subtract, bit0 carry. After a rotate, half-carry, extra and subtract are 0. Sign equals accumulator bit 7, zero is 1 when the accumulator is 0x00, and parity is 1 when the accumulator has an even number of one bits. Bit 5 keeps its value.
- R7: The carry flag (bit 0) keeps its value through a rotate.
- R8: Done is high for exactly one cycle. A start pulse while busy is ignored and does not change the running operation or cause a second one.
- R9: The load input (ld_i) writes acc_ld_i and flags_ld_i only while the block is idle. A load while busy has no effect.
- R10: Read data is taken only in the cycle after the read enable. Values on mem_rdata_i in other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for one rotate |
| dir_right_i | input | 1 | 0 = left rotate, 1 = right rotate |
| addr_i | input | AW | Memory byte address |
| ld_i | input | 1 | Load accumulator and flags (idle only) |
| acc_ld_i | input | 8 | Accumulator load value |
| flags_ld_i | input | 8 | Flag byte load value |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_re_o |
| mem_re_o | output | 1 | Memory read enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 8 | Flag byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong sequencer state shows at the memory port within one to three cycles of start. It appears as a missing or doubled read or write enable, a wrong address, or done landing in the wrong cycle. The monitor counts cycles from start to catch each of these. A wrong capture cycle for read data shows at the next done, because the bench memory drives a decoy byte on every cycle outside the read-data slot. A wrong nibble route or flag rule shows in the accumulator, the flags or the written byte at that same done. An accepted start or load while busy shows either as an extra bus access or as a mismatch in the final accumulator.

// File: rtl/nib_rot_pkg.sv
package nib_rot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } seq_st_e;

  localparam int FL_S = 7;
  localparam int FL_Z = 6;
  localparam int FL_H = 4;
  localparam int FL_X = 3;
  localparam int FL_P = 2;
  localparam int FL_N = 1;
  localparam int FL_C = 0;
endpackage

// File: rtl/nib_rot_fsm.sv
module nib_rot_fsm
  import nib_rot_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  output seq_st_e state_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_READ;
      ST_READ:  st_d = ST_WAIT;
      ST_WAIT:  st_d = ST_WRITE;
      ST_WRITE: st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  p_leave_idle_only_on_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !start_i) |=> st_q == ST_IDLE);
  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_READ) |=> st_q == ST_WAIT);
endmodule

// File: rtl/nib_rot_core.sv
// Twelve-bit group rotate: acc low nibble and both memory nibbles.
module nib_rot_core #(
  parameter int NIB = 4,
  localparam int DW = 2 * NIB
) (
  input  logic          right_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] mem_i,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] mem_o
);
  logic [NIB-1:0] a_hi, a_lo, m_hi, m_lo;

  assign a_hi = acc_i[DW-1:NIB];
  assign a_lo = acc_i[NIB-1:0];
  assign m_hi = mem_i[DW-1:NIB];
  assign m_lo = mem_i[NIB-1:0];

  always_comb begin
    if (right_i) begin
      acc_o = {a_hi, m_lo};
      mem_o = {a_lo, m_hi};
    end else begin
      acc_o = {a_hi, m_hi};
      mem_o = {m_lo, a_lo};
    end
  end
endmodule

// File: rtl/nib_rot_flags.sv
module nib_rot_flags
  import nib_rot_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc_i,
  input  logic [7:0]    flags_i,
  output logic [7:0]    flags_o
);
  always_comb begin
    flags_o       = flags_i;
    flags_o[FL_S] = acc_i[DW-1];
    flags_o[FL_Z] = (acc_i == '0);
    flags_o[FL_P] = ~^acc_i;
    flags_o[FL_H] = 1'b0;
    flags_o[FL_X] = 1'b0;
    flags_o[FL_N] = 1'b0;
  end
endmodule

// File: rtl/nib_rot_seq.sv
module nib_rot_seq
  import nib_rot_pkg::*;
#(
  parameter int AW  = 8,
  parameter int NIB = 4,
  localparam int DW = 2 * NIB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dir_right_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ld_i,
  input  logic [DW-1:0] acc_ld_i,
  input  logic [7:0]    flags_ld_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [DW-1:0] acc_o,
  output logic [7:0]    flags_o,
  output logic          busy_o,
  output logic          done_o
);
  seq_st_e       state;
  logic          idle;
  logic          go;
  logic          right_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] acc_q, wdata_q, acc_nx, mem_nx;
  logic [7:0]    flags_q, flags_nx;

  assign idle = (state == ST_IDLE);
  assign go   = start_i && idle;

  nib_rot_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .state_o (state)
  );

  nib_rot_core #(.NIB(NIB)) u_core (
    .right_i (right_q),
    .acc_i   (acc_q),
    .mem_i   (mem_rdata_i),
    .acc_o   (acc_nx),
    .mem_o   (mem_nx)
  );

  nib_rot_flags #(.DW(DW)) u_flags (
    .acc_i   (acc_nx),
    .flags_i (flags_q),
    .flags_o (flags_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      right_q <= 1'b0;
      addr_q  <= '0;
      acc_q   <= '0;
      flags_q <= '0;
      wdata_q <= '0;
    end else begin
      if (go) begin
        right_q <= dir_right_i;
        addr_q  <= addr_i;
      end
      if (ld_i && idle) begin
        acc_q   <= acc_ld_i;
        flags_q <= flags_ld_i;
      end
      // read data is valid in WAIT, one cycle after the read enable
      if (state == ST_WAIT) begin
        acc_q   <= acc_nx;
        flags_q <= flags_nx;
        wdata_q <= mem_nx;
      end
    end
  end

  assign mem_re_o    = (state == ST_READ);
  assign mem_we_o    = (state == ST_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign acc_o       = acc_q;
  assign flags_o     = flags_q;
  assign busy_o      = !idle;
  assign done_o      = (state == ST_DONE);

  p_bus_exclusive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  p_write_after_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($past(mem_re_o, 2) && mem_addr_o == $past(mem_addr_o, 2)));
  p_done_after_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_we_o));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_cleared_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!flags_o[FL_H] && !flags_o[FL_X] && !flags_o[FL_N]));
  p_carry_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_i && idle) |=> $stable(flags_o[FL_C]));
  p_no_load_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_re_o && !$past(mem_re_o)) |=> $stable(acc_o));
endmodule

// File: tb/tb_nib_rot_seq.sv
`timescale 1ns/1ps
module tb_nib_rot_seq;
  localparam int AW = 4;

  typedef struct {
    string      tag;
    logic [3:0] addr;
    logic [7:0] acc;
    logic [7:0] flags;
    logic [7:0] mem;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir_r = 1'b0, ld = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] acc_ld = '0, flags_ld = '0, rdata = '0;
  logic re, we, busy, done;
  logic [AW-1:0] maddr;
  logic [7:0] wdata, acc, flags;
  logic [7:0] mem [16];

  int total = 0, bad = 0, cyc = 0, n_rd = 0, n_wr = 0, pending = 0;
  logic done_prev = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  nib_rot_seq #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_right_i(dir_r),
    .addr_i(addr), .ld_i(ld), .acc_ld_i(acc_ld), .flags_ld_i(flags_ld),
    .mem_rdata_i(rdata), .mem_re_o(re), .mem_we_o(we), .mem_addr_o(maddr),
    .mem_wdata_o(wdata), .acc_o(acc), .flags_o(flags), .busy_o(busy),
    .done_o(done)
  );

  // memory: decoy byte on rdata except the cycle after a read
  always @(posedge clk) begin
    if (we) mem[maddr] <= wdata;
    rdata <= re ? mem[maddr] : 8'hC3;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(string tag, logic r, logic [3:0] a,
                                 logic [7:0] acc0, logic [7:0] f0, logic [7:0] m);
    exp_t e;
    e.tag = tag; e.addr = a; e.flags = f0;
    if (r) begin e.acc = {acc0[7:4], m[3:0]}; e.mem = {acc0[3:0], m[7:4]}; end
    else   begin e.acc = {acc0[7:4], m[7:4]}; e.mem = {m[3:0], acc0[3:0]}; end
    e.flags[7] = e.acc[7];
    e.flags[6] = (e.acc == 8'h00);
    e.flags[2] = ~^e.acc;
    e.flags[4] = 1'b0; e.flags[3] = 1'b0; e.flags[1] = 1'b0;
    return e;
  endfunction

  // driver: load, start, push expected; optional disturbance while busy
  task automatic run_op(string tag, logic r, logic [3:0] a, logic [7:0] acc0,
                        logic [7:0] f0, logic [7:0] m, bit disturb);
    @(posedge clk); #1;
    mem[a] = m;
    ld = 1'b1; acc_ld = acc0; flags_ld = f0;
    @(posedge clk); #1;
    ld = 1'b0;
    start = 1'b1; dir_r = r; addr = a;
    sb.push_back(model(tag, r, a, acc0, f0, m));
    pending++;
    @(posedge clk); #1;
    start = 1'b0;
    if (disturb) begin
      start = 1'b1; dir_r = ~r; addr = a + 4'd1;
      ld = 1'b1; acc_ld = ~acc0; flags_ld = ~f0;
      @(posedge clk); #1;
      @(posedge clk); #1;
      start = 1'b0; ld = 1'b0;
    end
    while (pending != 0) @(posedge clk);
    #1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (start && !busy) begin cyc = 0; n_rd = 0; n_wr = 0; end
      else cyc++;
      if (done_prev) chk("R8 done one cycle", done, 1'b0);
      done_prev = done;
      if (re) begin
        n_rd++;
        chk("R5 read cycle", cyc, 1);
      end
      if (we) begin
        n_wr++;
        chk("R5 write cycle", cyc, 3);
      end
      if (done) begin
        exp_t e;
        chk("R5 done cycle", cyc, 4);
        chk("R5 one read", n_rd, 1);
        chk("R5 one write", n_wr, 1);
        if (sb.size() == 0) chk("R8 unexpected done", 1, 0);
        else begin
          e = sb.pop_front();
          chk({e.tag, " R5 addr"}, maddr, e.addr);
          chk({e.tag, " R2 R4 acc"}, acc, e.acc);
          chk({e.tag, " R3 R4 mem"}, mem[e.addr], e.mem);
          chk({e.tag, " R6 R7 flags"}, flags, e.flags);
          pending--;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 acc", acc, 8'h00);
    chk("R1 flags", flags, 8'h00);
    chk("R1 bus", {re, we, busy, done}, 4'b0000);
    #1 rst_n = 1'b1;
    run_op("R2 R3 left", 1'b0, 4'd2, 8'h12, 8'h00, 8'h34, 1'b0);
    run_op("R4 right", 1'b1, 4'd5, 8'h12, 8'h00, 8'h34, 1'b0);
    run_op("R6 zero left", 1'b0, 4'd0, 8'h05, 8'hFF, 8'h0F, 1'b0);
    run_op("R7 carry right", 1'b1, 4'd15, 8'hA7, 8'h3B, 8'hE9, 1'b0);
    run_op("R6 sign right", 1'b1, 4'd9, 8'hF0, 8'h00, 8'h6E, 1'b0);
    run_op("R8 R9 busy start ld", 1'b0, 4'd7, 8'h9C, 8'h21, 8'h5D, 1'b1);
    run_op("R10 R9 busy right", 1'b1, 4'd3, 8'h4B, 8'hDE, 8'hC3, 1'b1);
    @(negedge clk);
    chk("R8 no extra op", {busy, done}, 2'b00);
    chk("R8 scoreboard empty", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule